// File: doc/BRIEF.md
# Partition-ID System Register Bank

This block holds the memory-partitioning system registers of one processor core: a read-only capability register, one partition register for each privilege level 0 to 3, a hypervisor partition-control register, a virtual-mapping valid register, up to eight virtual-mapping registers and a streaming-mode partition register. Every access presents a five-field system register number (op0, op1, CRn, CRm, op2). The bank decodes it to one register, clears reserved bits on writes, and assembles some read values from other registers. The only context inputs are the current level, the host-mode flag and the secure flag. Permission checks and traps are made by a separate block.

Reads are combinational from the stored state. Writes commit on the rising clock edge while `wr_en` is high. A number that matches no register raises `unmapped`, reads as zero and changes nothing.

Top module: `pid_sysreg_bank`

## Requirements
- R1: After reset every writable register reads zero, and the capability register reads 0x34000040001E0100.
- R2: The capability register (3,0,10,4,4) ignores writes and always reads its reset value.
- R3: The decoder maps the following numbers (op0,op1,CRn,CRm,op2): level 3 = 3,6,10,5,0; level 2 = 3,4,10,5,0; level 1 = 3,0,10,5,0; level 0 = 3,0,10,5,1; streaming = 3,0,10,5,3; hypervisor control = 3,4,10,4,0; mapping valid = 3,4,10,4,1; mapping register n = 3,4,10,6,n.
- R4: Reserved bits read 0 and drop writes. Writable bits: level 0 bits 47:0; level 1 bits 63, 60, 47:0; level 2 bits 63, 58, 49:0; level 3 bits 63:60, 47:0; hypervisor control bits 31, 8, 1, 0; mapping valid bits 31:0; streaming bits 47:40, 31:16; mapping registers all 64 bits.
- R5: A read of the level-1 or level-2 register returns bit 63 taken from bit 63 of the highest implemented level's register (level 3 by default).
- R6: A read of the level-1 register returns bit 60 equal to bit 60 of the level-3 register when `secure` is 1, and 0 when `secure` is 0.
- R7: With `cur_level` = 2 and `host_mode` = 1, the level-1 number 3,0,10,5,0 reaches the level-2 register for both reads and writes. Under any other context it reaches level 1.
- R8: The alias number 3,5,10,5,0 always reaches the level-1 register, whatever the context.
- R9: An unknown number drives `unmapped` high and `rdata` to zero, and a write to it leaves every register unchanged.
- R10: A write becomes visible on `rdata` after the next rising clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write the addressed register at the clock edge |
| sr_op0 | input | 2 | Register number field op0 |
| sr_op1 | input | 3 | Register number field op1 |
| sr_crn | input | 4 | Register number field CRn |
| sr_crm | input | 4 | Register number field CRm |
| sr_op2 | input | 3 | Register number field op2 |
| wdata | input | 64 | Write data |
| cur_level | input | 2 | Current privilege level |
| host_mode | input | 1 | Host mode of the level-2 software is on |
| secure | input | 1 | The access is secure |
| rdata | output | 64 | Read value of the addressed register |
| unmapped | output | 1 | The number matches no register |

## Verification
On every cycle the assertions check four things: a write to an unknown number leaves the stored state unchanged; the capability register always reads its fixed value; reserved bits of the level-0 register read zero; and bit 63 of level-1 and level-2 reads tracks the highest-level register. They also check that a non-secure read of level 1 shows bit 60 as zero, and that the host-mode redirection picks the level-2 register. The bench's scenarios cover the other behaviours: the write-then-read masks of every register kind, secure reporting of the level-3 bit, the alias that always reaches level 1, and the reset state restored in the middle of a run.

// File: rtl/pid_sysreg_pkg.sv
// Package: shared slot codes, widths and writable-bit masks for the
// partition-ID register bank. Assumes a 64-bit register width.
package pid_sysreg_pkg;
    localparam int DW      = 64;
    localparam int IDX_W   = 5;
    localparam int NSLOT   = 16;

    localparam logic [IDX_W-1:0] SR_ID   = 5'd0;
    localparam logic [IDX_W-1:0] SR_LV0  = 5'd1;
    localparam logic [IDX_W-1:0] SR_LV1  = 5'd2;
    localparam logic [IDX_W-1:0] SR_LV2  = 5'd3;
    localparam logic [IDX_W-1:0] SR_LV3  = 5'd4;
    localparam logic [IDX_W-1:0] SR_HCTL = 5'd5;
    localparam logic [IDX_W-1:0] SR_MVAL = 5'd6;
    localparam logic [IDX_W-1:0] SR_STRM = 5'd7;
    localparam logic [IDX_W-1:0] SR_MAP0 = 5'd8;
    localparam logic [IDX_W-1:0] SR_NONE = 5'd31;

    // Returns the bits of a slot that software may change.
    function automatic logic [DW-1:0] wr_mask(input int slot);
        case (slot)
            1:       wr_mask = 64'h0000_FFFF_FFFF_FFFF;
            2:       wr_mask = 64'h9000_FFFF_FFFF_FFFF;
            3:       wr_mask = 64'h8403_FFFF_FFFF_FFFF;
            4:       wr_mask = 64'hF000_FFFF_FFFF_FFFF;
            5:       wr_mask = 64'h0000_0000_8000_0103;
            6:       wr_mask = 64'h0000_0000_FFFF_FFFF;
            7:       wr_mask = 64'h0000_FF00_FFFF_0000;
            default: wr_mask = (slot >= 8 && slot < 16) ? '1 : '0;
        endcase
    endfunction
endpackage

// File: rtl/pid_sysreg_decode.sv
// Decoder: turns a five-field register number plus the level and host-mode
// context into a slot code. Assumes NUM_MAP <= 8 (op2 selects the mapping).
module pid_sysreg_decode
    import pid_sysreg_pkg::*;
#(
    parameter int NUM_MAP = 8
) (
    input  logic [1:0]       op0,
    input  logic [2:0]       op1,
    input  logic [3:0]       crn,
    input  logic [3:0]       crm,
    input  logic [2:0]       op2,
    input  logic [1:0]       cur_level,
    input  logic             host_mode,
    output logic [IDX_W-1:0] idx
);
    logic redirect;
    assign redirect = (cur_level == 2'd2) && host_mode;

    // Map the register number onto a slot, applying host-mode redirection.
    always_comb begin
        idx = SR_NONE;
        if (op0 == 2'd3 && crn == 4'd10) begin
            case ({op1, crm})
                {3'd0, 4'd4}: if (op2 == 3'd4) idx = SR_ID;
                {3'd0, 4'd5}: begin
                    case (op2)
                        3'd0:    idx = redirect ? SR_LV2 : SR_LV1;
                        3'd1:    idx = SR_LV0;
                        3'd3:    idx = SR_STRM;
                        default: idx = SR_NONE;
                    endcase
                end
                {3'd4, 4'd4}: begin
                    if (op2 == 3'd0) idx = SR_HCTL;
                    else if (op2 == 3'd1) idx = SR_MVAL;
                end
                {3'd4, 4'd5}: if (op2 == 3'd0) idx = SR_LV2;
                {3'd4, 4'd6}: if (32'(op2) < NUM_MAP) idx = SR_MAP0 | {2'b00, op2};
                {3'd5, 4'd5}: if (op2 == 3'd0) idx = SR_LV1;
                {3'd6, 4'd5}: if (op2 == 3'd0) idx = SR_LV3;
                default:      idx = SR_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pid_sysreg_store.sv
// Storage: one 64-bit register per slot, written under the slot's
// writable mask. The capability slot and unknown codes are never written.
module pid_sysreg_store
    import pid_sysreg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DW-1:0]               wdata,
    output logic [NSLOT-1:0][DW-1:0]    q
);
    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            localparam logic [DW-1:0] MASK = wr_mask(s);
            // Reset the slot to zero, or commit a masked write to it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[s] <= '0;
                else if (wr_en && idx == IDX_W'(s))
                    q[s] <= wdata & MASK;
            end
        end
    endgenerate

    // R9
    unmapped_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == SR_NONE) |=> $stable(q));
endmodule

// File: rtl/pid_sysreg_readmux.sv
// Read path: selects the addressed slot and builds the level-1 and level-2
// read values from the highest-level and level-3 registers.
module pid_sysreg_readmux
    import pid_sysreg_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE      = 64'h3400_0040_001E_0100,
    parameter int            HIGHEST_LEVEL = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         idx,
    input  logic [NSLOT-1:0][DW-1:0] q,
    input  logic                     secure,
    output logic [DW-1:0]            rdata
);
    localparam int TOP_SLOT = (HIGHEST_LEVEL >= 3) ? 4 : (HIGHEST_LEVEL == 2) ? 3 : 2;

    logic en_top;
    assign en_top = q[TOP_SLOT][DW-1];

    // Pick the read value for the addressed slot.
    always_comb begin
        rdata = '0;
        if (idx == SR_ID) begin
            rdata = ID_VALUE;
        end else if (idx == SR_LV1) begin
            rdata     = q[SR_LV1];
            rdata[63] = en_top;
            rdata[60] = secure ? q[SR_LV3][60] : 1'b0;
        end else if (idx == SR_LV2) begin
            rdata     = q[SR_LV2];
            rdata[63] = en_top;
        end else if (idx < IDX_W'(NSLOT)) begin
            rdata = q[idx[3:0]];
        end
    end

    // R2
    id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == SR_ID) |-> (rdata == ID_VALUE));
    // R4
    lv0_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == SR_LV0) |-> (rdata[63:48] == 16'h0));
    // R6
    nonsecure_fns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == SR_LV1 && !secure) |-> (rdata[60] == 1'b0));
endmodule

// File: rtl/pid_sysreg_bank.sv
// Top: partition-ID system register bank. Decodes the register number,
// stores the writable registers and assembles read values. Permission
// and trap decisions are assumed to be made outside this block.
module pid_sysreg_bank
    import pid_sysreg_pkg::*;
#(
    parameter logic [63:0] ID_VALUE      = 64'h3400_0040_001E_0100,
    parameter int          HIGHEST_LEVEL = 3,
    parameter int          NUM_MAP       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  sr_op0,
    input  logic [2:0]  sr_op1,
    input  logic [3:0]  sr_crn,
    input  logic [3:0]  sr_crm,
    input  logic [2:0]  sr_op2,
    input  logic [63:0] wdata,
    input  logic [1:0]  cur_level,
    input  logic        host_mode,
    input  logic        secure,
    output logic [63:0] rdata,
    output logic        unmapped
);
    localparam int TOP_SLOT = (HIGHEST_LEVEL >= 3) ? 4 : (HIGHEST_LEVEL == 2) ? 3 : 2;

    logic [IDX_W-1:0]         idx;
    logic [NSLOT-1:0][DW-1:0] q;

    pid_sysreg_decode #(.NUM_MAP(NUM_MAP)) u_decode (
        .op0(sr_op0), .op1(sr_op1), .crn(sr_crn), .crm(sr_crm), .op2(sr_op2),
        .cur_level(cur_level), .host_mode(host_mode), .idx(idx)
    );

    pid_sysreg_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(wdata), .q(q)
    );

    pid_sysreg_readmux #(.ID_VALUE(ID_VALUE), .HIGHEST_LEVEL(HIGHEST_LEVEL)) u_readmux (
        .clk(clk), .rst_n(rst_n), .idx(idx), .q(q), .secure(secure), .rdata(rdata)
    );

    // Flag numbers that reach no register.
    assign unmapped = (idx == SR_NONE);

    // R5
    en_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == SR_LV1 || idx == SR_LV2) |-> (rdata[63] == q[TOP_SLOT][63]));
    // R7
    host_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_level == 2'd2 && host_mode && sr_op0 == 2'd3 && sr_op1 == 3'd0 &&
         sr_crn == 4'd10 && sr_crm == 4'd5 && sr_op2 == 3'd0) |-> (idx == SR_LV2));
endmodule

// File: tb/pid_sysreg_bank_bench.sv
module pid_sysreg_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  sr_op0 = '0;
    logic [2:0]  sr_op1 = '0;
    logic [3:0]  sr_crn = '0;
    logic [3:0]  sr_crm = '0;
    logic [2:0]  sr_op2 = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  cur_level = 2'd1;
    logic        host_mode = 1'b0;
    logic        secure = 1'b0;
    logic [63:0] rdata;
    logic        unmapped;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pid_sysreg_bank u_pid_sysreg_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .sr_op0(sr_op0), .sr_op1(sr_op1), .sr_crn(sr_crn), .sr_crm(sr_crm), .sr_op2(sr_op2),
        .wdata(wdata), .cur_level(cur_level), .host_mode(host_mode), .secure(secure),
        .rdata(rdata), .unmapped(unmapped)
    );

    function automatic logic [15:0] rn(input int a, input int b, input int c, input int d, input int e);
        return {a[1:0], b[2:0], c[3:0], d[3:0], e[2:0]};
    endfunction

    localparam logic [15:0] N_LV1   = rn(3, 0, 10, 5, 0);
    localparam logic [15:0] N_LV0   = rn(3, 0, 10, 5, 1);
    localparam logic [15:0] N_LV2   = rn(3, 4, 10, 5, 0);
    localparam logic [15:0] N_LV3   = rn(3, 6, 10, 5, 0);
    localparam logic [15:0] N_ALIAS = rn(3, 5, 10, 5, 0);
    localparam logic [15:0] N_ID    = rn(3, 0, 10, 4, 4);
    localparam logic [15:0] N_MAP0  = rn(3, 4, 10, 6, 0);
    localparam logic [15:0] N_MAP3  = rn(3, 4, 10, 6, 3);

    typedef struct packed {
        logic [15:0] num;
        logic [63:0] wval;
        logic [63:0] exp;
    } vec_t;

    // Write then read back; level 3 bit 63 is zero and secure is off (R3, R4, R10).
    localparam vec_t VECS [10] = '{
        '{rn(3,0,10,5,1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF},
        '{rn(3,0,10,5,0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_FFFF_FFFF},
        '{rn(3,4,10,5,0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0403_FFFF_FFFF_FFFF},
        '{rn(3,4,10,4,0), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0103},
        '{rn(3,4,10,4,1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
        '{rn(3,0,10,5,3), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FF00_FFFF_0000},
        '{rn(3,4,10,6,0), 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
        '{rn(3,4,10,6,7), 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210},
        '{rn(3,6,10,5,0), 64'h0000_0000_0000_1234, 64'h0000_0000_0000_1234},
        '{rn(3,0,10,4,4), 64'hFFFF_FFFF_FFFF_FFFF, 64'h3400_0040_001E_0100}
    };

    task automatic set_ctx(input logic [1:0] lvl, input logic host, input logic sec);
        cur_level = lvl; host_mode = host; secure = sec;
    endtask

    task automatic put_num(input logic [15:0] n);
        {sr_op0, sr_op1, sr_crn, sr_crm, sr_op2} = n;
    endtask

    task automatic do_write(input logic [15:0] n, input logic [63:0] d);
        @(negedge clk);
        put_num(n); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_read(input logic [15:0] n, input logic [63:0] exp, input string req);
        @(negedge clk);
        put_num(n);
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    task automatic check_flag(input logic exp, input string req);
        checks++;
        if (unmapped !== exp) begin
            errors++;
            $display("FAIL %s: unmapped=%b expected=%b", req, unmapped, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_read(N_LV0, 64'h0, "R1");
        check_read(N_MAP3, 64'h0, "R1");
        check_read(N_ID, 64'h3400_0040_001E_0100, "R1");
        check_flag(1'b0, "R1");

        // Table walk: R2 R3 R4 R10
        for (int i = 0; i < 10; i++) begin
            do_write(VECS[i].num, VECS[i].wval);
            check_read(VECS[i].num, VECS[i].exp, "R4");
        end

        // R5 and R6: set level 3 bit 63 and bit 60
        do_write(N_LV3, 64'hF000_0000_0000_0000);
        check_read(N_LV1, 64'h8000_FFFF_FFFF_FFFF, "R5");
        check_read(N_LV2, 64'h8403_FFFF_FFFF_FFFF, "R5");
        set_ctx(2'd1, 1'b0, 1'b1);
        check_read(N_LV1, 64'h9000_FFFF_FFFF_FFFF, "R6");
        set_ctx(2'd1, 1'b0, 1'b0);

        // R7 host redirect at level 2
        set_ctx(2'd2, 1'b1, 1'b0);
        do_write(N_LV1, 64'h0000_0000_0000_00AA);
        check_read(N_LV2, 64'h8000_0000_0000_00AA, "R7");
        check_read(N_LV1, 64'h8000_0000_0000_00AA, "R7");
        // R8 alias still reaches level 1
        check_read(N_ALIAS, 64'h8000_FFFF_FFFF_FFFF, "R8");
        do_write(N_ALIAS, 64'h0000_0000_0000_0055);
        check_read(N_ALIAS, 64'h8000_0000_0000_0055, "R8");
        check_read(N_LV2, 64'h8000_0000_0000_00AA, "R8");
        // R7 host mode at level 1 does not redirect
        set_ctx(2'd1, 1'b1, 1'b0);
        check_read(N_LV1, 64'h8000_0000_0000_0055, "R7");

        // R9 unmapped numbers
        do_write(rn(3, 0, 10, 5, 2), 64'hFFFF_FFFF_FFFF_FFFF);
        check_read(rn(3, 0, 10, 5, 2), 64'h0, "R9");
        check_flag(1'b1, "R9");
        do_write(rn(3, 1, 10, 5, 0), 64'h1111_2222_3333_4444);
        check_read(N_LV0, 64'h0000_FFFF_FFFF_FFFF, "R9");
        check_read(N_MAP0, 64'h0123_4567_89AB_CDEF, "R9");
        check_read(N_LV3, 64'hF000_0000_0000_0000, "R9");
        check_flag(1'b0, "R9");

        // R1 reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_read(N_LV0, 64'h0, "R1");
        check_read(N_LV2, 64'h0, "R1");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule